// File: doc/BRIEF.md
# Multiplexed Keyscan Debouncer with Interrupt

This block reads up to eight key switches through two shared input lines. An external display scanner drives the digit lines low one at a time. While a digit line is low, a closed key pulls the matching input line low. Keys seen on input line 1 become keys 0 to 3, one per digit. Keys seen on input line 2 become keys 4 to 7.

The block counts multiplex cycles at the start of each digit-0 strobe and groups 32 of them into one keyscan cycle. It takes one sample of each key in each half of that cycle. At the end of the cycle it runs a two-sample test. The result goes into a live "pressed" register. Fresh presses build up in a sticky "debounced" register, and any fresh press raises an interrupt flag.

A read strobe clears the sticky register and the flag. The shared output pin is set by three configuration bits. It can be a display segment, a fixed logic level, or the interrupt in either polarity. A read-back byte reports the two input levels and the interrupt flag.

Top module: `kscan_debouncer`

## Requirements
- R1: The multiplex counter advances on each falling edge of digit line 0 and wraps from 31 to 0. Samples are taken in the multiplex cycles whose count is 8 and 24. The test runs when the highest scanned digit line (index = scan limit) rises during count 31.
- R2: A key is sampled as pressed when its input line is low while its digit line is low. This is captured when that digit line rises. Input 1 at digit d maps to key bit d, and input 2 at digit d maps to key bit d+4.
- R3: A key is reported only when it is pressed in both samples of a keyscan cycle. Reporting sets its bit in the debounced output and raises the interrupt flag. A key pressed in only one of the two samples is not reported and reads as released.
- R4: A key that was pressed in the previous test is not reported again. It must first test as released for one keyscan cycle.
- R5: Debounced bits are sticky and accumulate across keyscan cycles. A pulse on rd_clr_i clears all of them and the interrupt flag by the next clock. irq_o equals the OR of the debounced bits.
- R6: The pressed output holds the latest test result between tests. rd_clr_i leaves it unchanged.
- R7: port_cfg_i bit 2 enables keyscan on input 1 and bit 3 enables it on input 2. Keys on a disabled input always test as released.
- R8: For scan limit n, only keys on digits 0 to n take part, which is 2×(n+1) keys. All others test as released.
- R9: port_cfg_i[7:5] selects the pin use, and pin_level_o is 0 in segment mode.
  - 1xx: segment (pin_seg_o=1).
  - 000: level 0.
  - 001: level 1.
  - 010: active-low interrupt (level = not irq).
  - 011: active-high interrupt (level = irq).
- R10: cfg_rd_o returns port_cfg_i[7:3] in bits 7 to 3, the input 2 level in bit 2, the input 1 level in bit 1, and the interrupt flag in bit 0.
- R11: After reset, the pressed and debounced outputs and the interrupt are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dig_n_i | input | 4 | Digit strobes from the scanner, active low |
| in1_i | input | 1 | Synchronized input line 1 level |
| in2_i | input | 1 | Synchronized input line 2 level |
| port_cfg_i | input | 8 | Port configuration: pin use [7:5], keyscan enables [3:2] |
| scan_lim_i | input | 2 | Highest scanned digit index |
| rd_clr_i | input | 1 | Pulse after the debounced register is read |
| pressed_o | output | 8 | Latest test result per key |
| debounced_o | output | 8 | Sticky fresh-press flags per key |
| irq_o | output | 1 | Interrupt flag |
| pin_seg_o | output | 1 | Shared pin acts as a segment driver |
| pin_level_o | output | 1 | Logic level for the shared pin when not a segment |
| cfg_rd_o | output | 8 | Port configuration read-back byte |

## Verification
The bench drives keys that are pressed in only the first or only the second half of a keyscan cycle. A design that tested a single sample would report these keys. It also holds a key across several cycles, which catches a design that reports the same key on every cycle. It releases that key for one cycle and presses it again, which catches a design that never re-arms.

The bench clears the sticky flags and checks that the pressed register keeps its value. It presses every key while one input is disabled or the scan limit is reduced. A missing mask would then show keys outside the permitted set. Each pin-use code is checked against a known interrupt state, which exposes a swapped polarity.

// File: rtl/kscan_pkg.sv
package kscan_pkg;

    typedef enum logic [1:0] {
        PIN_SEGMENT,
        PIN_LOGIC,
        PIN_IRQ_LOW,
        PIN_IRQ_HIGH
    } pin_use_e;

    typedef struct packed {
        logic seg_mode;
        logic level;
    } pin_drive_t;

    function automatic pin_use_e decode_pin_use(input logic [2:0] sel);
        if (sel[2])
            return PIN_SEGMENT;
        else if (!sel[1])
            return PIN_LOGIC;
        else if (!sel[0])
            return PIN_IRQ_LOW;
        else
            return PIN_IRQ_HIGH;
    endfunction

    function automatic pin_drive_t pin_drive(input logic [2:0] sel, input logic irq);
        pin_drive_t d;
        d = '0;
        case (decode_pin_use(sel))
            PIN_SEGMENT:  d.seg_mode = 1'b1;
            PIN_LOGIC:    d.level    = sel[0];
            PIN_IRQ_LOW:  d.level    = ~irq;
            PIN_IRQ_HIGH: d.level    = irq;
            default:      d          = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/kscan_timebase.sv
module kscan_timebase #(
    parameter int NUM_DIGITS   = 4,
    parameter int MUX_PER_SCAN = 32,
    parameter int SAMPLE_SLOT  = 8,
    localparam int CNT_W = $clog2(MUX_PER_SCAN),
    localparam int LIM_W = $clog2(NUM_DIGITS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_DIGITS-1:0] dig_n_i,
    input  logic [LIM_W-1:0]      scan_lim_i,
    output logic [NUM_DIGITS-1:0] rise_o,
    output logic                  samp_en_o,
    output logic                  half_o,
    output logic                  eval_o
);
    localparam int HALF = MUX_PER_SCAN / 2;
    localparam int LAST = MUX_PER_SCAN - 1;

    logic [NUM_DIGITS-1:0] dig_q;
    logic [CNT_W-1:0]      cnt_q;
    logic [CNT_W-1:0]      slot;
    logic                  fall0;
    logic                  at_last;

    assign fall0   = dig_q[0] & ~dig_n_i[0];
    assign rise_o  = ~dig_q & dig_n_i;
    assign at_last = (cnt_q == CNT_W'(LAST));
    assign half_o  = (cnt_q >= CNT_W'(HALF));
    assign slot    = half_o ? cnt_q - CNT_W'(HALF) : cnt_q;
    assign samp_en_o = (slot == CNT_W'(SAMPLE_SLOT));
    assign eval_o  = rise_o[scan_lim_i] & at_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            dig_q <= '1;
            cnt_q <= CNT_W'(LAST);
        end else begin
            dig_q <= dig_n_i;
            if (fall0)
                cnt_q <= at_last ? '0 : cnt_q + 1'b1;
        end
    end

    // R1: the multiplex count wraps to zero after the last cycle of a scan
    assert_count_wrap_R1: assert property (@(posedge clk) disable iff (rst)
        (fall0 && at_last) |=> (cnt_q == '0));

    // R1: a test never falls in a sampling multiplex cycle
    assert_eval_not_sample_R1: assert property (@(posedge clk) disable iff (rst)
        eval_o |-> !samp_en_o);

endmodule

// File: rtl/kscan_sampler.sv
module kscan_sampler #(
    parameter int NUM_DIGITS = 4,
    localparam int NUM_KEYS = 2 * NUM_DIGITS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in1_i,
    input  logic                  in2_i,
    input  logic [NUM_DIGITS-1:0] rise_i,
    input  logic                  samp_en_i,
    input  logic                  half_i,
    input  logic                  clear_i,
    output logic [NUM_KEYS-1:0]   samp_a_o,
    output logic [NUM_KEYS-1:0]   samp_b_o
);
    logic in1_q, in2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            in1_q    <= 1'b1;
            in2_q    <= 1'b1;
            samp_a_o <= '0;
            samp_b_o <= '0;
        end else begin
            in1_q <= in1_i;
            in2_q <= in2_i;
            if (clear_i) begin
                samp_a_o <= '0;
                samp_b_o <= '0;
            end else if (samp_en_i) begin
                for (int d = 0; d < NUM_DIGITS; d++) begin
                    if (rise_i[d]) begin
                        if (!half_i) begin
                            samp_a_o[d]              <= ~in1_q;
                            samp_a_o[d + NUM_DIGITS] <= ~in2_q;
                        end else begin
                            samp_b_o[d]              <= ~in1_q;
                            samp_b_o[d + NUM_DIGITS] <= ~in2_q;
                        end
                    end
                end
            end
        end
    end

    // R2: samples only change at a digit strobe edge or a clear
    assert_sample_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!samp_en_i && !clear_i) |=> ($stable(samp_a_o) && $stable(samp_b_o)));

endmodule

// File: rtl/kscan_tracker.sv
module kscan_tracker #(
    parameter int NUM_DIGITS = 4,
    localparam int NUM_KEYS = 2 * NUM_DIGITS,
    localparam int LIM_W    = $clog2(NUM_DIGITS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                eval_i,
    input  logic                rd_clr_i,
    input  logic [1:0]          scan_en_i,
    input  logic [LIM_W-1:0]    scan_lim_i,
    input  logic [NUM_KEYS-1:0] samp_a_i,
    input  logic [NUM_KEYS-1:0] samp_b_i,
    output logic [NUM_KEYS-1:0] pressed_o,
    output logic [NUM_KEYS-1:0] debounced_o,
    output logic                irq_o
);
    logic [NUM_KEYS-1:0] mask;
    logic [NUM_KEYS-1:0] now_down;
    logic [NUM_KEYS-1:0] fresh;
    logic [NUM_KEYS-1:0] deb_kept;

    for (genvar k = 0; k < NUM_KEYS; k++) begin : g_mask
        localparam int DIG  = k % NUM_DIGITS;
        localparam int PORT = k / NUM_DIGITS;
        assign mask[k] = scan_en_i[PORT] && (scan_lim_i >= LIM_W'(DIG));
    end

    assign now_down = samp_a_i & samp_b_i & mask;
    assign fresh    = now_down & ~pressed_o;
    assign deb_kept = rd_clr_i ? '0 : debounced_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            pressed_o   <= '0;
            debounced_o <= '0;
            irq_o       <= 1'b0;
        end else if (eval_i) begin
            pressed_o   <= now_down;
            debounced_o <= deb_kept | fresh;
            irq_o       <= (irq_o & ~rd_clr_i) | (|fresh);
        end else if (rd_clr_i) begin
            debounced_o <= '0;
            irq_o       <= 1'b0;
        end
    end

    // R3: no debounced bit appears outside a test
    assert_no_report_idle_R3: assert property (@(posedge clk) disable iff (rst)
        !eval_i |=> ((debounced_o & ~$past(debounced_o)) == '0));

    // R4: a key pressed at the previous test is never newly reported
    assert_report_once_R4: assert property (@(posedge clk) disable iff (rst)
        eval_i |=> ((debounced_o & ~$past(debounced_o) & $past(pressed_o)) == '0));

    // R5: a clear with no test empties the sticky flags
    assert_read_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_clr_i && !eval_i) |=> (debounced_o == '0 && !irq_o));

    // R5: interrupt flag tracks the sticky flags
    assert_irq_flags_R5: assert property (@(posedge clk) disable iff (rst)
        irq_o == (|debounced_o));

    // R6: pressed register holds between tests
    assert_pressed_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !eval_i |=> $stable(pressed_o));

    // R8: no key outside the permitted set tests as pressed
    assert_mask_R8: assert property (@(posedge clk) disable iff (rst)
        eval_i |=> ((pressed_o & ~$past(mask)) == '0));

endmodule

// File: rtl/kscan_pin.sv
module kscan_pin
    import kscan_pkg::*;
(
    input  logic [7:0] port_cfg_i,
    input  logic       in1_i,
    input  logic       in2_i,
    input  logic       irq_i,
    output logic       pin_seg_o,
    output logic       pin_level_o,
    output logic [7:0] cfg_rd_o
);
    pin_drive_t drv;

    assign drv         = pin_drive(port_cfg_i[7:5], irq_i);
    assign pin_seg_o   = drv.seg_mode;
    assign pin_level_o = drv.level;
    assign cfg_rd_o    = {port_cfg_i[7:3], in2_i, in1_i, irq_i};

endmodule

// File: rtl/kscan_debouncer.sv
module kscan_debouncer #(
    parameter int NUM_DIGITS   = 4,
    parameter int MUX_PER_SCAN = 32,
    parameter int SAMPLE_SLOT  = 8,
    localparam int NUM_KEYS = 2 * NUM_DIGITS,
    localparam int LIM_W    = $clog2(NUM_DIGITS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_DIGITS-1:0] dig_n_i,
    input  logic                  in1_i,
    input  logic                  in2_i,
    input  logic [7:0]            port_cfg_i,
    input  logic [LIM_W-1:0]      scan_lim_i,
    input  logic                  rd_clr_i,
    output logic [NUM_KEYS-1:0]   pressed_o,
    output logic [NUM_KEYS-1:0]   debounced_o,
    output logic                  irq_o,
    output logic                  pin_seg_o,
    output logic                  pin_level_o,
    output logic [7:0]            cfg_rd_o
);
    logic [NUM_DIGITS-1:0] rise;
    logic                  samp_en, half, eval;
    logic [NUM_KEYS-1:0]   samp_a, samp_b;

    kscan_timebase #(
        .NUM_DIGITS  (NUM_DIGITS),
        .MUX_PER_SCAN(MUX_PER_SCAN),
        .SAMPLE_SLOT (SAMPLE_SLOT)
    ) u_timebase (
        .clk       (clk),
        .rst       (rst),
        .dig_n_i   (dig_n_i),
        .scan_lim_i(scan_lim_i),
        .rise_o    (rise),
        .samp_en_o (samp_en),
        .half_o    (half),
        .eval_o    (eval)
    );

    kscan_sampler #(.NUM_DIGITS(NUM_DIGITS)) u_sampler (
        .clk      (clk),
        .rst      (rst),
        .in1_i    (in1_i),
        .in2_i    (in2_i),
        .rise_i   (rise),
        .samp_en_i(samp_en),
        .half_i   (half),
        .clear_i  (eval),
        .samp_a_o (samp_a),
        .samp_b_o (samp_b)
    );

    kscan_tracker #(.NUM_DIGITS(NUM_DIGITS)) u_tracker (
        .clk        (clk),
        .rst        (rst),
        .eval_i     (eval),
        .rd_clr_i   (rd_clr_i),
        .scan_en_i  (port_cfg_i[3:2]),
        .scan_lim_i (scan_lim_i),
        .samp_a_i   (samp_a),
        .samp_b_i   (samp_b),
        .pressed_o  (pressed_o),
        .debounced_o(debounced_o),
        .irq_o      (irq_o)
    );

    kscan_pin u_pin (
        .port_cfg_i (port_cfg_i),
        .in1_i      (in1_i),
        .in2_i      (in2_i),
        .irq_i      (irq_o),
        .pin_seg_o  (pin_seg_o),
        .pin_level_o(pin_level_o),
        .cfg_rd_o   (cfg_rd_o)
    );

endmodule

// File: tb/kscan_debouncer_tb.sv
module kscan_debouncer_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] dig_n = 4'hF;
    logic       in1 = 1'b1, in2 = 1'b1;
    logic [7:0] cfg = 8'h6C;
    logic [1:0] lim = 2'd3;
    logic       rd_clr = 1'b0;
    logic [7:0] pressed, debounced, cfg_rd;
    logic       irq, pin_seg, pin_level;

    int checks = 0, failures = 0;
    bit done = 0;
    logic [7:0] exp_p = 8'h00, exp_d = 8'h00;

    always #2 clk = ~clk;

    kscan_debouncer u_dut (
        .clk(clk), .rst(rst), .dig_n_i(dig_n), .in1_i(in1), .in2_i(in2),
        .port_cfg_i(cfg), .scan_lim_i(lim), .rd_clr_i(rd_clr),
        .pressed_o(pressed), .debounced_o(debounced), .irq_o(irq),
        .pin_seg_o(pin_seg), .pin_level_o(pin_level), .cfg_rd_o(cfg_rd)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] key_mask(input logic [7:0] c, input logic [1:0] l);
        logic [7:0] m = 8'h00;
        for (int k = 0; k < 8; k++)
            m[k] = (k < 4 ? c[2] : c[3]) && ((k % 4) <= l);
        return m;
    endfunction

    task automatic strobe_digit(input int d, input logic l1, input logic l2);
        @(negedge clk);
        dig_n = ~(4'b1 << d);
        in1 = l1;
        in2 = l2;
        repeat (3) @(negedge clk);
        dig_n = 4'hF;
        in1 = 1'b1;
        in2 = 1'b1;
    endtask

    // one keyscan cycle: pattern pa in first half, pb in second half
    task automatic run_scan(input logic [7:0] pa, input logic [7:0] pb);
        logic [7:0] now, pat;
        for (int m = 0; m < 32; m++) begin
            pat = (m < 16) ? pa : pb;
            for (int d = 0; d < 4; d++)
                strobe_digit(d, ~pat[d], ~pat[d + 4]);
        end
        @(negedge clk);
        @(negedge clk);
        now   = pa & pb & key_mask(cfg, lim);
        exp_d = exp_d | (now & ~exp_p);
        exp_p = now;
    endtask

    task automatic read_clear();
        @(negedge clk);
        rd_clr = 1'b1;
        @(negedge clk);
        rd_clr = 1'b0;
        exp_d = 8'h00;
        @(negedge clk);
    endtask

    task automatic check_keys(input string req);
        check({req, " pressed"}, pressed, exp_p);
        check({req, " debounced"}, debounced, exp_d);
        check({req, " irq"}, {7'b0, irq}, {7'b0, |exp_d});
    endtask

    task automatic t_reset();
        check_keys("R11 reset");
    endtask

    task automatic t_basic_press();
        run_scan(8'h21, 8'h21);
        check_keys("R2 mapping");
        check("R2 expected keys", pressed, 8'h21);
    endtask

    task automatic t_held_once();
        read_clear();
        check_keys("R6 pressed kept after clear");
        check("R6 pressed value", pressed, 8'h21);
        run_scan(8'h21, 8'h21);
        check_keys("R4 held key not reported");
        check("R4 debounced stays 0", debounced, 8'h00);
        run_scan(8'h00, 8'h00);
        check_keys("R4 release");
        run_scan(8'h01, 8'h01);
        check_keys("R4 re-press");
        check("R4 re-press reported", debounced, 8'h01);
    endtask

    task automatic t_bounce();
        read_clear();
        run_scan(8'h00, 8'h00);
        run_scan(8'h02, 8'h00);
        check_keys("R3 first-half only");
        check("R3 no report", debounced, 8'h00);
        run_scan(8'h00, 8'h40);
        check_keys("R3 second-half only");
        check("R3 none pressed", pressed, 8'h00);
    endtask

    task automatic t_sticky();
        run_scan(8'h10, 8'h10);
        run_scan(8'h18, 8'h18);
        check_keys("R5 accumulate");
        check("R5 sticky value", debounced, 8'h18);
        read_clear();
        check_keys("R5 cleared");
    endtask

    task automatic t_enable();
        run_scan(8'h00, 8'h00);
        cfg = 8'h64;
        run_scan(8'hFF, 8'hFF);
        check_keys("R7 input2 disabled");
        check("R7 only input1 keys", pressed, 8'h0F);
        cfg = 8'h68;
        run_scan(8'h00, 8'h00);
        run_scan(8'hFF, 8'hFF);
        check("R7 only input2 keys", pressed, 8'hF0);
        cfg = 8'h6C;
    endtask

    task automatic t_limit();
        read_clear();
        run_scan(8'h00, 8'h00);
        lim = 2'd1;
        run_scan(8'hFF, 8'hFF);
        check_keys("R8 limit 1");
        check("R8 four keys", pressed, 8'h33);
        lim = 2'd0;
        run_scan(8'hFF, 8'hFF);
        check("R8 limit 0", pressed, 8'h11);
        lim = 2'd3;
    endtask

    task automatic t_pin();
        // irq is high here (keys were reported in t_limit)
        check("R9 irq precondition", {7'b0, irq}, 8'h01);
        cfg = 8'h8C; #1;
        check("R9 segment mode", {6'b0, pin_seg, pin_level}, 8'h02);
        cfg = 8'h0C; #1;
        check("R9 logic 0", {6'b0, pin_seg, pin_level}, 8'h00);
        cfg = 8'h2C; #1;
        check("R9 logic 1", {6'b0, pin_seg, pin_level}, 8'h01);
        cfg = 8'h4C; #1;
        check("R9 irq active low", {6'b0, pin_seg, pin_level}, 8'h00);
        cfg = 8'h6C; #1;
        check("R9 irq active high", {6'b0, pin_seg, pin_level}, 8'h01);
        read_clear();
        cfg = 8'h4C; #1;
        check("R9 active low idle", {6'b0, pin_seg, pin_level}, 8'h01);
        cfg = 8'h6C;
    endtask

    task automatic t_readback();
        @(negedge clk);
        in1 = 1'b0;
        in2 = 1'b1;
        #1;
        check("R10 readback", cfg_rd, 8'h6C);
        in1 = 1'b1;
        in2 = 1'b0;
        cfg = 8'hA8;
        #1;
        check("R10 readback levels", cfg_rd, 8'hAA);
        in2 = 1'b1;
        cfg = 8'h6C;
        run_scan(8'h80, 8'h80);
        #1;
        check("R10 readback irq", cfg_rd, 8'h6F);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic_press();
        t_held_once();
        t_bounce();
        t_sticky();
        t_enable();
        t_limit();
        t_pin();
        t_readback();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule